// File: doc/BRIEF.md
# Serial Flash Status Register and Write Protection Controller

This block holds the 16-bit status register of a serial NOR flash device and decides, command by command, whether a state-changing request goes ahead. The command parser in front of it delivers one decoded operation per clock as a strobe with a 3-bit code and, for a status write, the 16-bit value to load. The controller checks the request against four things: the write-enable latch, the busy flag, the chip-erase guard bits, and a protection mode. The protection mode comes from two status-protect bits and the level of the write-protect pin. The controller returns a one-cycle accept or reject pulse.

An accepted status write, program or erase raises the busy bit for a fixed number of clocks, which stands in for the array operation. When that time ends, the write-enable latch clears. A power-cycle input models a supply drop and restore. It clears the volatile bits and releases the supply lock-down mode, but it does not release the permanent lock mode. The quad-enable bit is exported so that pad logic can switch the protect and hold pins over to data lines.

The command interface is a plain strobe with no back-pressure. The block answers every command in the following cycle, so no ready signal is needed.

Top module: `spi_flash_wp_ctrl`

## Requirements
- R1: After reset the status register reads 0, quad_en is 0, and neither cmd_accept nor cmd_reject is asserted.
- R2: The status bits are laid out as follows: bit 0 busy, bit 1 write-enable latch, bits 6:2 block-protect, bit 7 protect-mode low bit, bit 8 protect-mode high bit, bit 9 quad enable. Bits 15:10 always read 0. A status write loads only bits 9:2 and leaves bits 0 and 1 untouched by its data.
- R3: Command codes are 0 write-enable, 1 write-disable, 2 status write, 3 page program, 4 sector erase, 5 block erase, 6 chip erase and 7 no operation. When the block is idle, write-enable sets the latch and write-disable clears it, and both are accepted.
- R4: A status write, program or erase issued while the latch is 0 is rejected and changes nothing.
- R5: With protect mode 00 a status write with the latch set is accepted whatever the pin level. With mode 01 the same write is rejected while wp_n is 0 and accepted while wp_n is 1.
- R6: In mode 10 every status write is rejected. A power_cycle pulse returns the mode to 00, clears the busy bit and the latch, and keeps the block-protect and quad-enable bits.
- R7: Mode 11 rejects every status write, and a power_cycle pulse leaves it unchanged.
- R8: A chip erase is accepted only when block-protect bits 2:0 are all 0. Bits 4:3 do not block it.
- R9: An accepted status write, program or erase sets the busy bit for exactly BUSY_CYCLES clocks. Every command code 0 to 6 that arrives while busy is rejected. The latch clears on the clock at which the busy bit falls.
- R10: Each command with code 0 to 6 produces exactly one pulse, on cmd_accept or on cmd_reject, in the cycle after it is presented. Code 7 produces no pulse and changes no state, and a command presented together with power_cycle is dropped without a pulse.
- R11: quad_en equals status bit 9 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, full return to defaults |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 3 | Command code, encoded as in R3 |
| cmd_wdata | input | 16 | Value for a status write |
| wp_n | input | 1 | Write-protect pin level |
| power_cycle | input | 1 | One-cycle supply drop and restore event |
| cmd_accept | output | 1 | Previous cycle's command was executed |
| cmd_reject | output | 1 | Previous cycle's command was refused |
| status | output | 16 | Status register contents |
| quad_en | output | 1 | Quad-enable bit, selects pin functions |

## Verification
The assertions assume that the wp_n pin is already synchronous to clk and stable around each edge. They also assume that power_cycle and cmd_valid are treated as independent, so a command may coincide with a power cycle and must then be dropped. The stimulus changes every input only on the falling clock edge. The random status-write values make the permanent-lock pattern rare, and the stimulus issues a full reset at intervals so that a permanent lock does not freeze the rest of the run.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int SR_W     = 16;
  localparam int WIP_BIT  = 0;
  localparam int WEL_BIT  = 1;
  localparam int BP_LSB   = 2;
  localparam int BP_W     = 5;
  localparam int SRP0_BIT = 7;
  localparam int SRP1_BIT = 8;
  localparam int QE_BIT   = 9;

  typedef enum logic [2:0] {
    OP_WEN    = 3'd0,
    OP_WDIS   = 3'd1,
    OP_SRWR   = 3'd2,
    OP_PROG   = 3'd3,
    OP_SERASE = 3'd4,
    OP_BERASE = 3'd5,
    OP_CERASE = 3'd6,
    OP_NONE   = 3'd7
  } op_t;

  typedef enum logic [1:0] {
    LOCK_SOFT    = 2'b00,
    LOCK_PIN     = 2'b01,
    LOCK_SUPPLY  = 2'b10,
    LOCK_FOREVER = 2'b11
  } lock_t;
endpackage

// File: rtl/wp_mode_decode.sv
module wp_mode_decode
  import flash_wp_pkg::*;
(
  input  logic [1:0] srp,
  input  logic       wp_n,
  output lock_t      mode,
  output logic       sr_writable
);
  always_comb begin
    mode = lock_t'(srp);
    unique case (mode)
      LOCK_SOFT:    sr_writable = 1'b1;
      LOCK_PIN:     sr_writable = wp_n;
      LOCK_SUPPLY:  sr_writable = 1'b0;
      default:      sr_writable = 1'b0;
    endcase
  end

  always_comb begin
    if (mode == LOCK_FOREVER || mode == LOCK_SUPPLY)
      p_locked_modes_r7: assert (!sr_writable);
  end
endmodule

// File: rtl/wp_busy_timer.sv
module wp_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1)) && !clr;

  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && !start) |=> (cnt == $past(cnt) - 1'b1));
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/wp_cmd_arbiter.sv
module wp_cmd_arbiter
  import flash_wp_pkg::*;
(
  input  logic       cmd_valid,
  input  op_t        op,
  input  logic       power_cycle,
  input  logic       busy,
  input  logic       wel,
  input  logic       sr_writable,
  input  logic       ce_guard_clear,
  output logic       accept_now,
  output logic       reject_now,
  output logic       set_wel,
  output logic       clr_wel,
  output logic       load_sr,
  output logic       start_busy
);
  logic live;
  logic pass;

  assign live = cmd_valid && (op != OP_NONE) && !power_cycle;

  always_comb begin
    pass = 1'b0;
    if (!busy) begin
      unique case (op)
        OP_WEN, OP_WDIS:             pass = 1'b1;
        OP_SRWR:                     pass = wel && sr_writable;
        OP_PROG, OP_SERASE, OP_BERASE: pass = wel;
        OP_CERASE:                   pass = wel && ce_guard_clear;
        default:                     pass = 1'b0;
      endcase
    end
  end

  assign accept_now = live && pass;
  assign reject_now = live && !pass;
  assign set_wel    = accept_now && (op == OP_WEN);
  assign clr_wel    = accept_now && (op == OP_WDIS);
  assign load_sr    = accept_now && (op == OP_SRWR);
  assign start_busy = accept_now && (op inside {OP_SRWR, OP_PROG, OP_SERASE, OP_BERASE, OP_CERASE});

  always_comb begin
    p_onehot_decide_r10: assert (!(accept_now && reject_now));
  end
endmodule

// File: rtl/spi_flash_wp_ctrl.sv
module spi_flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_code,
  input  logic [15:0] cmd_wdata,
  input  logic        wp_n,
  input  logic        power_cycle,
  output logic        cmd_accept,
  output logic        cmd_reject,
  output logic [15:0] status,
  output logic        quad_en
);
  logic [BP_W-1:0] bp;
  logic [1:0]      srp;
  logic            qe;
  logic            wel;
  logic            busy;
  logic            done;
  logic            sr_writable;
  lock_t           mode;
  op_t             op;
  logic            accept_now, reject_now, set_wel, clr_wel, load_sr, start_busy;

  assign op = op_t'(cmd_code);

  wp_mode_decode u_mode (
    .srp         (srp),
    .wp_n        (wp_n),
    .mode        (mode),
    .sr_writable (sr_writable)
  );

  wp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (power_cycle),
    .start (start_busy),
    .busy  (busy),
    .done  (done)
  );

  wp_cmd_arbiter u_arb (
    .cmd_valid      (cmd_valid),
    .op             (op),
    .power_cycle    (power_cycle),
    .busy           (busy),
    .wel            (wel),
    .sr_writable    (sr_writable),
    .ce_guard_clear (bp[2:0] == 3'b000),
    .accept_now     (accept_now),
    .reject_now     (reject_now),
    .set_wel        (set_wel),
    .clr_wel        (clr_wel),
    .load_sr        (load_sr),
    .start_busy     (start_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp         <= '0;
      srp        <= 2'b00;
      qe         <= 1'b0;
      wel        <= 1'b0;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= accept_now;
      cmd_reject <= reject_now;
      if (power_cycle) begin
        wel <= 1'b0;
        if (mode == LOCK_SUPPLY) srp <= 2'b00;
      end else begin
        if (set_wel)             wel <= 1'b1;
        else if (clr_wel || done) wel <= 1'b0;
        if (load_sr) begin
          bp  <= cmd_wdata[BP_LSB +: BP_W];
          srp <= {cmd_wdata[SRP1_BIT], cmd_wdata[SRP0_BIT]};
          qe  <= cmd_wdata[QE_BIT];
        end
      end
    end
  end

  always_comb begin
    status           = '0;
    status[WIP_BIT]  = busy;
    status[WEL_BIT]  = wel;
    status[BP_LSB +: BP_W] = bp;
    status[SRP0_BIT] = srp[0];
    status[SRP1_BIT] = srp[1];
    status[QE_BIT]   = qe;
  end

  assign quad_en = qe;

  p_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wel && cmd_code inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) |=> !cmd_accept);
  p_ce_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd6 && bp[2:0] != 3'b000) |=> !cmd_accept);
  p_busy_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && !power_cycle && cmd_code != 3'd7) |=> cmd_reject);
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !power_cycle) |=> !wel);
  p_lockdown_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srp == 2'b10 && !power_cycle) |=> (srp == 2'b10));
  p_lockdown_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srp == 2'b10 && power_cycle) |=> (srp == 2'b00 && !busy && !wel));
  p_otp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srp == 2'b11) |=> (srp == 2'b11));
  p_single_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));
  p_nop_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_code == 3'd7 || power_cycle) |=> (!cmd_accept && !cmd_reject));
endmodule

// File: tb/spi_flash_wp_ctrl_bench.sv
module spi_flash_wp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBUSY = 8;
  localparam logic [2:0] C_WEN = 3'd0, C_WDIS = 3'd1, C_SRWR = 3'd2, C_PROG = 3'd3,
                         C_SE = 3'd4, C_BE = 3'd5, C_CE = 3'd6, C_NOP = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd7;
  logic [15:0] cmd_wdata = '0;
  logic        wp_n = 1'b1;
  logic        power_cycle = 1'b0;
  logic        cmd_accept, cmd_reject, quad_en;
  logic [15:0] status;

  int n_checks = 0;
  int n_fail = 0;
  bit reported = 0;

  logic [4:0] m_bp;
  logic [1:0] m_srp;
  logic       m_qe, m_wel;
  int         m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_wp_ctrl #(.BUSY_CYCLES(NBUSY)) u_spi_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .wp_n(wp_n), .power_cycle(power_cycle),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .status(status), .quad_en(quad_en)
  );

  function automatic logic [15:0] exp_status();
    return {6'b0, m_qe, m_srp, m_bp, m_wel, (m_cnt != 0)};
  endfunction

  function automatic bit f_writable(logic [1:0] srp, logic wp);
    return (srp == 2'b00) || (srp == 2'b01 && wp);
  endfunction

  function automatic logic [15:0] mk(logic qe, logic [1:0] srp, logic [4:0] bp);
    return {6'b0, qe, srp, bp, 2'b00};
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic cycle(bit v, logic [2:0] c, logic [15:0] d, bit wp, bit pc, string tag);
    bit ea, er, busy0, ok;
    ea = 0; er = 0;
    cmd_valid = v; cmd_code = c; cmd_wdata = d; wp_n = wp; power_cycle = pc;
    busy0 = (m_cnt != 0);
    @(posedge clk);
    if (pc) begin
      m_cnt = 0; m_wel = 0;
      if (m_srp == 2'b10) m_srp = 2'b00;
    end else begin
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_wel = 0;
      end
      if (v && c != C_NOP) begin
        ok = 0;
        if (!busy0) begin
          case (c)
            C_WEN:  begin ok = 1; m_wel = 1; end
            C_WDIS: begin ok = 1; m_wel = 0; end
            C_SRWR: ok = m_wel && f_writable(m_srp, wp);
            C_CE:   ok = m_wel && (m_bp[2:0] == 3'b000);
            default: ok = m_wel;
          endcase
          if (ok && c == C_SRWR) begin
            m_bp = d[6:2]; m_srp = d[8:7]; m_qe = d[9];
          end
          if (ok && c != C_WEN && c != C_WDIS) m_cnt = NBUSY;
        end
        ea = ok; er = !ok;
      end
    end
    @(negedge clk);
    cmd_valid = 0; power_cycle = 0;
    check(tag, "accept", {15'b0, cmd_accept}, {15'b0, ea});
    check(tag, "reject", {15'b0, cmd_reject}, {15'b0, er});
    check(tag, "status", status, exp_status());
    check(tag, "quad_en R11", {15'b0, quad_en}, {15'b0, m_qe});
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(0, C_NOP, '0, 1, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; power_cycle = 0;
    m_bp = '0; m_srp = '0; m_qe = 0; m_wel = 0; m_cnt = 0;
    @(negedge clk); @(negedge clk);
    check("R1", "status", status, 16'h0000);
    check("R1", "resp", {14'b0, cmd_accept, cmd_reject}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "status after release", status, 16'h0000);
    check("R1", "quad_en", {15'b0, quad_en}, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] d;
    logic [2:0]  c;
    do_reset();
    // R4: no latch
    cycle(1, C_SRWR, mk(1, 2'b00, 5'h1F), 1, 0, "R4");
    cycle(1, C_PROG, '0, 1, 0, "R4");
    cycle(1, C_CE, '0, 1, 0, "R4");
    // R3
    cycle(1, C_WEN, '0, 1, 0, "R3");
    cycle(1, C_WDIS, '0, 1, 0, "R3");
    cycle(1, C_WEN, '0, 1, 0, "R3");
    // R2 reserved and WIP/WEL bits in data ignored, R11 quad enable
    cycle(1, C_SRWR, 16'hFC03 | mk(1, 2'b00, 5'b00101), 1, 0, "R2");
    cycle(1, C_PROG, '0, 1, 0, "R9");
    cycle(1, C_WEN, '0, 1, 0, "R9");
    idle(NBUSY, "R9");
    // R8 chip erase guard
    cycle(1, C_WEN, '0, 1, 0, "R8");
    cycle(1, C_CE, '0, 1, 0, "R8");
    cycle(1, C_SRWR, mk(0, 2'b00, 5'b11000), 0, 0, "R5");
    idle(NBUSY, "R9");
    cycle(1, C_WEN, '0, 1, 0, "R8");
    cycle(1, C_CE, '0, 1, 0, "R8");
    idle(NBUSY + 1, "R9");
    // R10 no-op and command with power cycle
    cycle(1, C_WEN, '0, 1, 0, "R10");
    cycle(1, C_NOP, 16'hFFFF, 1, 0, "R10");
    cycle(1, C_WDIS, '0, 1, 1, "R10");
    // R5 pin mode
    cycle(1, C_WEN, '0, 1, 0, "R5");
    cycle(1, C_SRWR, mk(0, 2'b01, 5'b0), 1, 0, "R5");
    idle(NBUSY, "R5");
    cycle(1, C_WEN, '0, 1, 0, "R5");
    cycle(1, C_SRWR, mk(0, 2'b01, 5'h3), 0, 0, "R5");
    cycle(1, C_SRWR, mk(0, 2'b01, 5'h3), 1, 0, "R5");
    idle(NBUSY, "R5");
    // R6 supply lock-down
    cycle(1, C_WEN, '0, 1, 0, "R6");
    cycle(1, C_SRWR, mk(1, 2'b10, 5'h1), 1, 0, "R6");
    idle(NBUSY, "R6");
    cycle(1, C_WEN, '0, 0, 0, "R6");
    cycle(1, C_SRWR, mk(0, 2'b00, 5'h0), 1, 0, "R6");
    cycle(1, C_PROG, '0, 1, 0, "R6");
    cycle(0, C_NOP, '0, 1, 1, "R6");
    // R7 permanent lock
    cycle(1, C_WEN, '0, 1, 0, "R7");
    cycle(1, C_SRWR, mk(0, 2'b11, 5'h2), 1, 0, "R7");
    idle(NBUSY, "R7");
    cycle(1, C_WEN, '0, 1, 0, "R7");
    cycle(1, C_SRWR, mk(0, 2'b00, 5'h0), 1, 0, "R7");
    cycle(0, C_NOP, '0, 1, 1, "R7");
    cycle(1, C_WEN, '0, 1, 0, "R7");
    cycle(1, C_SRWR, mk(0, 2'b00, 5'h0), 1, 0, "R7");
    // random mix
    void'($urandom(32'h5EED_1234));
    for (int blk = 0; blk < 8; blk++) begin
      do_reset();
      for (int i = 0; i < 500; i++) begin
        c = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 2) == 0) c = C_WEN;
        d = 16'($urandom);
        if (d[8:7] == 2'b11 && $urandom_range(0, 15) != 0) d[8] = 1'b0;
        cycle($urandom_range(0, 9) < 7, c, d, 1'($urandom), $urandom_range(0, 39) == 0,
              "random R4 R5 R9 R10");
      end
    end
    report();
  end
endmodule